// File: doc/BRIEF.md
# Two-Link Queue-Length Priority Input Buffer

This block is the input buffer and admission stage of one switching element in a slotted, self-routing multistage fabric. In each network cycle two upstream links may each offer one packet. A packet is a single word made of a 3-bit sender queue-length field, a routing tag and a payload. Accepted packets go into one shared first-in first-out buffer. The forwarding side takes packets from the head of that buffer, and each packet leaves with the output port chosen by one bit of its routing tag.

Admission depends on the free space at the start of the cycle. If two or more slots are free, both offered packets are taken. If only one slot is free and both links offer, that is a conflict. In priority mode the packet whose sender reports the longer queue wins. In baseline mode a pseudo-random bit picks the winner. A link that loses is told so on a registered block line in the next cycle and keeps its packet. In first-stage mode there is no upstream hold: every offer is consumed in its cycle, and any packet that does not fit is dropped and flagged. The block also exports its own occupancy, saturated to 3 bits, so that its outgoing packets can carry it as their queue-length field.

Each input link is a valid/ready pair, and a packet transfers when both are high. In normal mode `inN_ready` is a combinational function of the registered fill count, the two valids, the two queue-length fields and the mode pins. A sender that sees ready low must hold its packet. The output is also valid/ready: `out_data` and `out_port` stay fixed while `out_valid` is high and `out_ready` is low.

Top module: `prio_admit`

## Requirements
- R1: Packets leave in the order they were accepted. When both links are accepted in the same cycle, the link 0 packet leaves before the link 1 packet.
- R2: When at least two slots are free at the start of a cycle, every offered packet is accepted in that cycle. Free slots are DEPTH minus the registered fill count; a pop in the same cycle does not add a free slot.
- R3: The fill count never exceeds DEPTH. When no slot is free, no offer is accepted.
- R4: In priority mode (`cfg_no_prio`=0), when exactly one slot is free and both links offer, only the packet with the larger queue-length field (data bits [13:11]) is accepted. If the two fields are equal, link 0 wins.
- R5: In baseline mode (`cfg_no_prio`=1), in the same conflict exactly one packet is accepted. The pick comes from an 8-bit LFSR that steps every cycle, so over many conflicts both links win.
- R6: In normal mode (`cfg_first_stage`=0), bit i of `blk_q` is 1 in the cycle after link i offered a packet that was not accepted, and 0 otherwise.
- R7: In first-stage mode (`cfg_first_stage`=1), both ready outputs are always 1. An offer that does not fit is discarded, bit i of `drop_q` is 1 in the next cycle, and `blk_q` stays 0.
- R8: `out_port` equals bit STAGE of the head packet's routing tag, which occupies data bits [10:8]. The payload is bits [7:0].
- R9: `occ_sat` equals the registered fill count, clamped to 7.
- R10: After reset the buffer is empty, `out_valid` is 0, `occ_sat` is 0, and `blk_q` and `drop_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_prio | input | 1 | 1 selects baseline pseudo-random conflict resolution |
| cfg_first_stage | input | 1 | 1 selects first-stage drop behaviour |
| in0_valid | input | 1 | Link 0 offers a packet |
| in0_ready | output | 1 | Link 0 packet is consumed this cycle |
| in0_data | input | QW+TAGW+PAYW | Link 0 packet: queue length, tag, payload |
| in1_valid | input | 1 | Link 1 offers a packet |
| in1_ready | output | 1 | Link 1 packet is consumed this cycle |
| in1_data | input | QW+TAGW+PAYW | Link 1 packet |
| blk_q | output | 2 | Per-link block indication, one cycle after the offer |
| drop_q | output | 2 | Per-link drop indication in first-stage mode, one cycle after the offer |
| out_valid | output | 1 | Head packet available |
| out_ready | input | 1 | Forwarding side takes the head packet |
| out_data | output | QW+TAGW+PAYW | Head packet |
| out_port | output | 1 | Output port chosen by the head packet's tag bit |
| occ_sat | output | QW | Own occupancy, saturated, for outgoing preambles |

## Verification
If the fill count is wrong, the effect shows at `occ_sat` on the next cycle. It also shows in the ready outputs the next time a cycle has one or two free slots. A wrong write slot or a wrong pointer wrap shows up as a payload out of order or duplicated at `out_data` during the next drain. A reversed comparison or a wrong tie rule shows at the ready outputs in the same cycle as the conflict, and in `blk_q` one cycle later. The bench sweeps every fill level with every valid pattern and every pair of queue-length values, then drains the buffer after each case. Any of these faults is therefore seen within a few cycles of the case that triggers it.

// File: rtl/prio_admit_pkg.sv
package prio_admit_pkg;
  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;

  typedef enum logic {WIN_L0 = 1'b0, WIN_L1 = 1'b1} win_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    // polynomial x^8 + x^6 + x^5 + x^4 + 1
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/pa_lfsr.sv
module pa_lfsr
  import prio_admit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rnd
);
  logic [LFSR_W-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= LFSR_SEED;
    else        st <= lfsr_step(st);
  end

  assign rnd = st[0];
endmodule

// File: rtl/pa_arbiter.sv
module pa_arbiter
  import prio_admit_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int QW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          v0,
  input  logic          v1,
  input  logic [QW-1:0] q0,
  input  logic [QW-1:0] q1,
  input  logic [CW-1:0] cnt,
  input  logic          no_prio,
  input  logic          rnd,
  output logic          acc0,
  output logic          acc1
);
  logic [CW:0] free;
  win_e        win;

  assign free = (CW+1)'(DEPTH) - {1'b0, cnt};

  always_comb begin
    // conflict winner: larger sender queue, tie to link 0, or a random bit
    if (no_prio) win = rnd ? WIN_L1 : WIN_L0;
    else         win = (q0 >= q1) ? WIN_L0 : WIN_L1;
    acc0 = 1'b0;
    acc1 = 1'b0;
    if (free >= (CW+1)'(2)) begin
      acc0 = v0;
      acc1 = v1;
    end else if (free == (CW+1)'(1)) begin
      if (v0 && v1) begin
        acc0 = (win == WIN_L0);
        acc1 = (win == WIN_L1);
      end else begin
        acc0 = v0;
        acc1 = v1;
      end
    end
  end
endmodule

// File: rtl/pa_fifo.sv
module pa_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 14,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr0,
  input  logic [DW-1:0] d0,
  input  logic          wr1,
  input  logic [DW-1:0] d1,
  input  logic          rd,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      // link 0 takes the first free slot, link 1 the one after it
      if (wr0 && wr1) begin
        mem[wp]      <= d0;
        mem[nxt(wp)] <= d1;
        wp           <= nxt(nxt(wp));
      end else if (wr0 || wr1) begin
        mem[wp] <= wr0 ? d0 : d1;
        wp      <= nxt(wp);
      end
      if (rd) rp <= nxt(rp);
      cnt <= cnt + CW'(wr0) + CW'(wr1) - CW'(rd);
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/prio_admit.sv
module prio_admit #(
  parameter int DEPTH = 8,
  parameter int QW    = 3,
  parameter int TAGW  = 3,
  parameter int PAYW  = 8,
  parameter int STAGE = 1,
  localparam int PKTW = QW + TAGW + PAYW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_no_prio,
  input  logic            cfg_first_stage,
  input  logic            in0_valid,
  output logic            in0_ready,
  input  logic [PKTW-1:0] in0_data,
  input  logic            in1_valid,
  output logic            in1_ready,
  input  logic [PKTW-1:0] in1_data,
  output logic [1:0]      blk_q,
  output logic [1:0]      drop_q,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PKTW-1:0] out_data,
  output logic            out_port,
  output logic [QW-1:0]   occ_sat
);
  logic          acc0, acc1, rnd, pop;
  logic [CW-1:0] fill_cnt;

  pa_lfsr u_rng (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  pa_arbiter #(.DEPTH(DEPTH), .QW(QW)) u_arb (
    .v0(in0_valid), .v1(in1_valid),
    .q0(in0_data[PKTW-1 -: QW]), .q1(in1_data[PKTW-1 -: QW]),
    .cnt(fill_cnt), .no_prio(cfg_no_prio), .rnd(rnd),
    .acc0(acc0), .acc1(acc1)
  );

  pa_fifo #(.DEPTH(DEPTH), .DW(PKTW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr0(acc0), .d0(in0_data),
    .wr1(acc1), .d1(in1_data),
    .rd(pop), .head(out_data), .cnt(fill_cnt)
  );

  assign out_valid = (fill_cnt != '0);
  assign pop       = out_valid && out_ready;
  assign out_port  = out_data[PAYW + STAGE];
  assign in0_ready = cfg_first_stage ? 1'b1 : acc0;
  assign in1_ready = cfg_first_stage ? 1'b1 : acc1;
  assign occ_sat   = (int'(fill_cnt) > (2**QW - 1)) ? {QW{1'b1}} : QW'(fill_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      drop_q <= '0;
    end else if (cfg_first_stage) begin
      blk_q  <= '0;
      drop_q <= {in1_valid && !acc1, in0_valid && !acc0};
    end else begin
      blk_q  <= {in1_valid && !acc1, in0_valid && !acc0};
      drop_q <= '0;
    end
  end
endmodule

// File: rtl/prio_admit_chk.sv
module prio_admit_chk #(
  parameter int DEPTH = 8,
  parameter int QW    = 3,
  parameter int PKTW  = 14,
  parameter int PAYW  = 8,
  parameter int STAGE = 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_no_prio,
  input logic            cfg_first_stage,
  input logic            in0_valid,
  input logic            in1_valid,
  input logic [PKTW-1:0] in0_data,
  input logic [PKTW-1:0] in1_data,
  input logic            in0_ready,
  input logic            in1_ready,
  input logic [1:0]      blk_q,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PKTW-1:0] out_data,
  input logic            out_port,
  input logic [CW-1:0]   fill_cnt,
  input logic            acc0,
  input logic            acc1
);
  logic conflict;
  assign conflict = in0_valid && in1_valid && (int'(fill_cnt) == DEPTH - 1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_cnt) <= DEPTH);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(fill_cnt) == int'($past(fill_cnt)) + int'($past(acc0))
             + int'($past(acc1)) - int'($past(out_valid && out_ready)));

  p_prio_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !cfg_no_prio) |->
      ($countones({acc0, acc1}) == 1) &&
      ((in1_data[PKTW-1 -: QW] > in0_data[PKTW-1 -: QW]) ? acc1 : acc0));

  p_single_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $countones({acc0, acc1}) == 1);

  p_block_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_first_stage && in0_valid && !in0_ready) |=> blk_q[0]);

  p_first_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_first_stage |-> (in0_ready && in1_ready));

  p_port_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_port == out_data[PAYW + STAGE]));
endmodule

bind prio_admit prio_admit_chk #(
  .DEPTH(DEPTH), .QW(QW), .PKTW(PKTW), .PAYW(PAYW), .STAGE(STAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_no_prio(cfg_no_prio),
  .cfg_first_stage(cfg_first_stage),
  .in0_valid(in0_valid), .in1_valid(in1_valid),
  .in0_data(in0_data), .in1_data(in1_data),
  .in0_ready(in0_ready), .in1_ready(in1_ready), .blk_q(blk_q),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_port(out_port), .fill_cnt(fill_cnt), .acc0(acc0), .acc1(acc1)
);

// File: tb/prio_admit_bench.sv
`timescale 1ns/100ps
module prio_admit_bench;
  localparam int DEPTH = 8;
  localparam int STAGE = 1;
  localparam int PKTW  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_no_prio = 1'b0, cfg_first_stage = 1'b0;
  logic in0_valid = 1'b0, in1_valid = 1'b0, out_ready = 1'b0;
  logic [PKTW-1:0] in0_data = '0, in1_data = '0;
  logic in0_ready, in1_ready, out_valid, out_port;
  logic [1:0] blk_q, drop_q;
  logic [PKTW-1:0] out_data;
  logic [2:0] occ_sat;

  int total = 0, bad = 0;
  logic [PKTW-1:0] exq [0:31];
  int exn = 0;
  logic [7:0] uid = 8'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_admit #(.DEPTH(DEPTH), .STAGE(STAGE)) u_prio_admit (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PKTW-1:0] mk(input logic [2:0] q);
    uid = uid + 8'd1;
    return {q, uid[2:0], uid};
  endfunction

  task automatic push1();
    in0_data = mk(3'd0);
    in0_valid = 1'b1;
    exq[exn] = in0_data; exn++;
    @(posedge clk); @(negedge clk);
    in0_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int i = 0; i < exn; i++) begin
      #1;
      chk(out_valid && out_data == exq[i], "R1 order", int'(out_data), int'(exq[i]));
      chk(out_port == exq[i][8+STAGE], "R8 port", int'(out_port), int'(exq[i][8+STAGE]));
      @(posedge clk); @(negedge clk);
    end
    #1;
    chk(!out_valid, "R1 empty after drain", int'(out_valid), 0);
    out_ready = 1'b0;
    exn = 0;
  endtask

  // offer at a negedge; expected acceptance from the requirements
  task automatic offer(input bit v0, input bit v1, input logic [2:0] q0,
                       input logic [2:0] q1, input bit first);
    int free;
    bit a0, a1;
    logic [PKTW-1:0] p0, p1;
    free = DEPTH - exn;
    p0 = mk(q0); p1 = mk(q1);
    if (free >= 2) begin a0 = v0; a1 = v1; end
    else if (free == 1) begin
      if (v0 && v1) begin a0 = (q0 >= q1); a1 = !a0; end
      else begin a0 = v0; a1 = v1; end
    end else begin a0 = 0; a1 = 0; end
    in0_valid = v0; in1_valid = v1; in0_data = p0; in1_data = p1;
    #1;
    if (first) chk(in0_ready && in1_ready, "R7 always ready", int'({in1_ready, in0_ready}), 3);
    else if (free >= 2) chk({in1_ready, in0_ready} == {a1, a0}, "R2 both fit",
                            int'({in1_ready, in0_ready}), int'({a1, a0}));
    else if (free == 1 && v0 && v1) chk({in1_ready, in0_ready} == {a1, a0}, "R4 priority",
                            int'({in1_ready, in0_ready}), int'({a1, a0}));
    else chk({in1_ready, in0_ready} == {a1, a0}, "R3 space limit",
             int'({in1_ready, in0_ready}), int'({a1, a0}));
    if (a0) begin exq[exn] = p0; exn++; end
    if (a1) begin exq[exn] = p1; exn++; end
    @(posedge clk); @(negedge clk);
    in0_valid = 1'b0; in1_valid = 1'b0;
    if (first) begin
      chk(drop_q == {v1 && !a1, v0 && !a0}, "R7 drop flag", int'(drop_q), int'({v1 && !a1, v0 && !a0}));
      chk(blk_q == 2'b00, "R7 no block", int'(blk_q), 0);
    end else begin
      chk(blk_q == {v1 && !a1, v0 && !a0}, "R6 block flag", int'(blk_q), int'({v1 && !a1, v0 && !a0}));
    end
    chk(occ_sat == 3'((exn > 7) ? 7 : exn), "R9 occupancy", int'(occ_sat), (exn > 7) ? 7 : exn);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, w1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!out_valid, "R10 reset valid", int'(out_valid), 0);
    chk(occ_sat == 3'd0, "R10 reset occupancy", int'(occ_sat), 0);
    chk(blk_q == 2'b00 && drop_q == 2'b00, "R10 reset flags", int'({blk_q, drop_q}), 0);
    @(negedge clk);

    // sweep fill level x valid pattern x queue-length pairs
    for (int c = 0; c <= DEPTH; c++)
      for (int v = 0; v < 4; v++)
        for (int qq = 0; qq < 64; qq++) begin
          if (v != 3 && qq > 1) continue;
          for (int k = 0; k < c; k++) push1();
          offer(v[0], v[1], 3'(qq >> 3), 3'(qq), 1'b0);
          drain();
        end

    // baseline random mode: exactly one winner, both links win over time
    cfg_no_prio = 1'b1;
    w0 = 0; w1 = 0;
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < DEPTH - 1; k++) push1();
      in0_data = mk(3'd7); in1_data = mk(3'd0);
      in0_valid = 1'b1; in1_valid = 1'b1;
      #1;
      chk((in0_ready ^ in1_ready) == 1'b1, "R5 single winner", int'({in1_ready, in0_ready}), 1);
      if (in0_ready) begin w0++; exq[exn] = in0_data; exn++; end
      if (in1_ready) begin w1++; exq[exn] = in1_data; exn++; end
      @(posedge clk); @(negedge clk);
      in0_valid = 1'b0; in1_valid = 1'b0;
      drain();
      repeat (t % 3) @(negedge clk);
    end
    chk(w0 > 0 && w1 > 0, "R5 both links win", w0 * 100 + w1, 1);
    cfg_no_prio = 1'b0;

    // first-stage mode: full buffer drops both, one free slot keeps the winner
    cfg_first_stage = 1'b1;
    for (int k = 0; k < DEPTH; k++) push1();
    offer(1'b1, 1'b1, 3'd4, 3'd4, 1'b1);
    drain();
    for (int k = 0; k < DEPTH - 1; k++) push1();
    offer(1'b1, 1'b1, 3'd2, 3'd5, 1'b1);
    drain();
    offer(1'b1, 1'b1, 3'd1, 3'd1, 1'b1);
    drain();
    cfg_first_stage = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule